// File: doc/BRIEF.md
# High-Side Overcurrent Fault Latch

This block watches six high-side output channels for overcurrent. Channel 0 is the first high-side output and has its own rules. Channels 1 to 5 share one rule set. For each channel the block receives a digitised load current in milliamps and a commanded enable. It compares the current with a threshold chosen by configuration inputs. It then requires the overcurrent to last for a selectable deglitch window before it accepts a fault.

Once a channel's fault is confirmed, the block does three things. It latches a per-channel status bit and raises a summary bit. It also holds that channel's gated output low. A single-cycle clear-fault pulse releases every latched channel. Channel 0 can have its protection switched off, so that loads with heavy inrush current, such as lamps, can be driven. All configuration and status use plain parallel ports.

Top module: `hs_ocp_latch`

## Requirements
- R1: During and directly after a synchronous active-low reset, every `ocp_flag` bit and `hs_fault` are 0, and `drv_en` equals `cmd_en`.
- R2: For channels 1..5, `thr_hi[c-1]` = 0 selects a 250 mA threshold and 1 selects 500 mA.
- R3: For channel 0, `ch0_lowrds` = 0 selects a 500 mA threshold and 1 selects 1500 mA.
- R4: While `ch0_ocp_off` is 1, channel 0 never raises a new fault, whatever its current.
- R5: Overcurrent means current strictly above the threshold. A current equal to the threshold never faults.
- R6: `dg_sel[2c+1:2c]` = s gives a window of N = 8<<s clocks (8, 16, 32 or 64). The flag rises after the N-th consecutive edge that sees overcurrent. Any edge without overcurrent restarts the count.
- R7: Overcurrent counts only while `cmd_en[c]` is 1. An edge with the command low restarts the count.
- R8: A confirmed fault sets `ocp_flag[c]` and forces `drv_en[c]` to 0.
- R9: `hs_fault` is 1 exactly when any `ocp_flag` bit is 1.
- R10: A latched flag, and the forced-off output that goes with it, persist until an edge with `clr_flt` = 1. That edge clears them.
- R11: If a fault is confirmed on the same edge as `clr_flt`, that channel's flag is set and stays set.
- R12: Channels are independent. A fault on one channel leaves every other channel's flag and `drv_en` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| clr_flt | input | 1 | Single-cycle pulse that clears latched faults |
| cmd_en | input | 6 | Commanded enable, one bit per channel |
| cur_ma | input | 72 | Load current, 12 bits per channel in mA; channel c is at [12c+11:12c] |
| thr_hi | input | 5 | Threshold select for channels 1..5 (bit c-1) |
| ch0_lowrds | input | 1 | Channel 0 on-resistance mode; sets its threshold |
| ch0_ocp_off | input | 1 | Turns off overcurrent detection on channel 0 |
| dg_sel | input | 12 | Deglitch select, 2 bits per channel |
| drv_en | output | 6 | Gated output enable per channel |
| ocp_flag | output | 6 | Latched overcurrent status per channel |
| hs_fault | output | 1 | Summary of all channel faults |

## Verification
The bench targets the exact length of the deglitch window. A run of N-1 overcurrent cycles must not latch, while a run of N cycles must; an off-by-one counter would latch one edge early or late. It also checks that a single clean cycle restarts the count, which catches a counter that pauses instead of restarting. Currents equal to each threshold are applied to expose a non-strict comparison. Channel 0 is driven through both of its threshold values and through its disable input, which catches a design that applies the wrong threshold mapping to channel 0. Finally, a clear pulse is made to coincide with a fault being confirmed on another channel. This exposes a design that lets the clear win, or that clears only some channels.

// File: rtl/hs_ocp_pkg.sv
package hs_ocp_pkg;
    parameter int NCH      = 6;
    parameter int CUR_W    = 12;
    parameter int DG_BASE  = 8;
    parameter int DG_SEL_W = 2;
    parameter int TH_LO_MA    = 250;
    parameter int TH_HI_MA    = 500;
    parameter int TH_CH0_LO   = 500;
    parameter int TH_CH0_HI   = 1500;
    localparam int DG_MAX  = DG_BASE << ((1 << DG_SEL_W) - 1);
    localparam int CNT_W   = $clog2(DG_MAX) + 1;
endpackage

// File: rtl/hs_ocp_thr.sv
module hs_ocp_thr
    import hs_ocp_pkg::*;
#(
    parameter bit IS_CH0 = 1'b0
) (
    input  logic             sel,
    input  logic             dis,
    output logic [CUR_W-1:0] thr,
    output logic             mon_en
);
    localparam logic [CUR_W-1:0] T_LO = CUR_W'(IS_CH0 ? TH_CH0_LO : TH_LO_MA);
    localparam logic [CUR_W-1:0] T_HI = CUR_W'(IS_CH0 ? TH_CH0_HI : TH_HI_MA);

    always_comb begin
        thr    = sel ? T_HI : T_LO;
        mon_en = ~dis;
    end
endmodule

// File: rtl/hs_ocp_dgl.sv
module hs_ocp_dgl
    import hs_ocp_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                clr,
    input  logic                cmd,
    input  logic [CUR_W-1:0]    cur,
    input  logic [CUR_W-1:0]    thr,
    input  logic                mon_en,
    input  logic [DG_SEL_W-1:0] dg,
    output logic                flag,
    output logic                drv
);
    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             flt;
    } dgl_st_t;

    dgl_st_t st_d, st_q;
    logic [CNT_W-1:0] lim;
    logic             over;
    logic             hit;

    always_comb begin
        st_d = st_q;
        lim  = CNT_W'(DG_BASE) << dg;
        over = cmd & ~st_q.flt & mon_en & (cur > thr);
        hit  = over & (st_q.cnt == lim - CNT_W'(1));
        if (over && !hit) st_d.cnt = st_q.cnt + CNT_W'(1);
        else              st_d.cnt = '0;
        st_d.flt = hit | (st_q.flt & ~clr);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign flag = st_q.flt;
    assign drv  = cmd & ~st_q.flt;
endmodule

// File: rtl/hs_ocp_latch.sv
module hs_ocp_latch
    import hs_ocp_pkg::*;
(
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      clr_flt,
    input  logic [NCH-1:0]            cmd_en,
    input  logic [NCH*CUR_W-1:0]      cur_ma,
    input  logic [NCH-2:0]            thr_hi,
    input  logic                      ch0_lowrds,
    input  logic                      ch0_ocp_off,
    input  logic [NCH*DG_SEL_W-1:0]   dg_sel,
    output logic [NCH-1:0]            drv_en,
    output logic [NCH-1:0]            ocp_flag,
    output logic                      hs_fault
);
    for (genvar c = 0; c < NCH; c++) begin : g_ch
        logic [CUR_W-1:0] thr;
        logic             mon_en;
        logic             sel;
        logic             dis;

        if (c == 0) begin : g_first
            assign sel = ch0_lowrds;
            assign dis = ch0_ocp_off;
        end else begin : g_rest
            assign sel = thr_hi[c-1];
            assign dis = 1'b0;
        end

        hs_ocp_thr #(.IS_CH0(c == 0)) u_thr (
            .sel    (sel),
            .dis    (dis),
            .thr    (thr),
            .mon_en (mon_en)
        );

        hs_ocp_dgl u_dgl (
            .clk    (clk),
            .rst_n  (rst_n),
            .clr    (clr_flt),
            .cmd    (cmd_en[c]),
            .cur    (cur_ma[c*CUR_W +: CUR_W]),
            .thr    (thr),
            .mon_en (mon_en),
            .dg     (dg_sel[c*DG_SEL_W +: DG_SEL_W]),
            .flag   (ocp_flag[c]),
            .drv    (drv_en[c])
        );
    end

    assign hs_fault = |ocp_flag;
endmodule

// File: rtl/hs_ocp_latch_chk.sv
module hs_ocp_latch_chk
    import hs_ocp_pkg::*;
(
    input logic                    clk,
    input logic                    rst_n,
    input logic                    clr_flt,
    input logic [NCH-1:0]          cmd_en,
    input logic [NCH*CUR_W-1:0]    cur_ma,
    input logic                    ch0_ocp_off,
    input logic [NCH-1:0]          drv_en,
    input logic [NCH-1:0]          ocp_flag,
    input logic                    hs_fault
);
    // R1
    reset_clear_chk: assert property (@(posedge clk) !rst_n |=> (ocp_flag == '0));

    // R9
    summary_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hs_fault == (ocp_flag != '0));

    // R4
    ch0_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ch0_ocp_off && !ocp_flag[0]) |=> !ocp_flag[0]);

    for (genvar c = 0; c < NCH; c++) begin : g_a
        // R7
        rise_needs_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(ocp_flag[c]) |-> $past(cmd_en[c]));
        // R5
        rise_needs_over_chk: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(ocp_flag[c]) |-> ($past(cur_ma[c*CUR_W +: CUR_W]) > CUR_W'(TH_LO_MA)));
        // R10
        hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (ocp_flag[c] && !clr_flt) |=> ocp_flag[c]);
        // R8
        forced_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(ocp_flag[c]) |-> !drv_en[c]);
    end
endmodule

bind hs_ocp_latch hs_ocp_latch_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .clr_flt     (clr_flt),
    .cmd_en      (cmd_en),
    .cur_ma      (cur_ma),
    .ch0_ocp_off (ch0_ocp_off),
    .drv_en      (drv_en),
    .ocp_flag    (ocp_flag),
    .hs_fault    (hs_fault)
);

// File: tb/hs_ocp_latch_tb.sv
`timescale 1ns/1ps
module hs_ocp_latch_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        clr_flt = 1'b0;
    logic [5:0]  cmd_en = '0;
    logic [71:0] cur_ma = '0;
    logic [4:0]  thr_hi = '0;
    logic        ch0_lowrds = 1'b0;
    logic        ch0_ocp_off = 1'b0;
    logic [11:0] dg_sel = '0;
    logic [5:0]  drv_en;
    logic [5:0]  ocp_flag;
    logic        hs_fault;

    int n_vec = 0;
    int n_bad = 0;
    bit done = 0;

    int mcnt [6];
    bit mflt [6];

    always #2.5 clk = ~clk;

    hs_ocp_latch u_dut (
        .clk(clk), .rst_n(rst_n), .clr_flt(clr_flt), .cmd_en(cmd_en),
        .cur_ma(cur_ma), .thr_hi(thr_hi), .ch0_lowrds(ch0_lowrds),
        .ch0_ocp_off(ch0_ocp_off), .dg_sel(dg_sel), .drv_en(drv_en),
        .ocp_flag(ocp_flag), .hs_fault(hs_fault)
    );

    // Behavioural reference, stepped on each rising edge
    always @(posedge clk) begin
        for (int c = 0; c < 6; c++) begin
            int  th, lim, cur;
            bit  cond, hit;
            if (c == 0) th = ch0_lowrds ? 1500 : 500;
            else        th = thr_hi[c-1] ? 500 : 250;
            cur  = int'(cur_ma[c*12 +: 12]);
            lim  = 8 * (1 << dg_sel[c*2 +: 2]);
            cond = cmd_en[c] && !mflt[c] && !(c == 0 && ch0_ocp_off) && (cur > th);
            hit  = cond && (mcnt[c] + 1 >= lim);
            if (!rst_n) begin
                mcnt[c] = 0;
                mflt[c] = 0;
            end else begin
                mcnt[c] = (cond && !hit) ? mcnt[c] + 1 : 0;
                mflt[c] = hit || (mflt[c] && !clr_flt);
            end
        end
    end

    // Compare against the reference on every falling edge
    always @(negedge clk) begin
        if (rst_n && !done) begin
            bit any;
            any = 0;
            n_vec++;
            for (int c = 0; c < 6; c++) begin
                any |= mflt[c];
                if (ocp_flag[c] !== mflt[c]) begin
                    n_bad++;
                    $display("FAIL R6 ch%0d flag act=%0b exp=%0b", c, ocp_flag[c], mflt[c]);
                end
                if (drv_en[c] !== (cmd_en[c] & ~mflt[c])) begin
                    n_bad++;
                    $display("FAIL R8 ch%0d drv act=%0b exp=%0b", c, drv_en[c], cmd_en[c] & ~mflt[c]);
                end
            end
            if (hs_fault !== any) begin
                n_bad++;
                $display("FAIL R9 summary act=%0b exp=%0b", hs_fault, any);
            end
        end
    end

    task automatic tick(int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            @(negedge clk);
        end
    endtask

    task automatic chk(string req, int act, int exp);
        n_vec++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s act=%0d exp=%0d", req, act, exp);
        end
    endtask

    task automatic set_cur(int c, int v);
        cur_ma[c*12 +: 12] = 12'(v);
    endtask

    task automatic pulse_clr();
        clr_flt = 1'b1;
        tick(1);
        clr_flt = 1'b0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        cmd_en = 6'h3f;
        @(negedge clk);
        tick(3);
        chk("R1 flags in reset", int'(ocp_flag), 0);
        rst_n = 1'b1;
        tick(1);
        chk("R1 flags after reset", int'(ocp_flag), 0);
        chk("R1 summary after reset", int'(hs_fault), 0);
        chk("R1 drv after reset", int'(drv_en), 63);

        // R6 / R2 low threshold: window 8, restart on a clean cycle
        set_cur(1, 251);
        tick(7);
        chk("R6 ch1 after 7", int'(ocp_flag[1]), 0);
        set_cur(1, 0);
        tick(1);
        set_cur(1, 251);
        tick(7);
        chk("R6 ch1 restart", int'(ocp_flag[1]), 0);
        tick(1);
        chk("R2 ch1 250mA fault", int'(ocp_flag[1]), 1);
        chk("R8 ch1 forced off", int'(drv_en[1]), 0);
        chk("R9 summary set", int'(hs_fault), 1);
        chk("R12 others untouched", int'(drv_en & 6'h3d), 6'h3d);
        set_cur(1, 0);
        tick(3);
        chk("R10 persists", int'(ocp_flag[1]), 1);
        pulse_clr();
        chk("R10 cleared", int'(ocp_flag[1]), 0);
        chk("R10 drv back", int'(drv_en[1]), 1);

        // R5 / R2 high threshold with window 64
        thr_hi[1] = 1'b1;
        dg_sel[5:4] = 2'd3;
        set_cur(2, 500);
        tick(70);
        chk("R5 equal no fault", int'(ocp_flag[2]), 0);
        set_cur(2, 501);
        tick(63);
        chk("R6 ch2 after 63", int'(ocp_flag[2]), 0);
        tick(1);
        chk("R2 ch2 500mA fault", int'(ocp_flag[2]), 1);
        set_cur(2, 0);
        pulse_clr();

        // R3 channel 0 mapping, window 16
        dg_sel[1:0] = 2'd1;
        set_cur(0, 501);
        tick(15);
        chk("R3 ch0 after 15", int'(ocp_flag[0]), 0);
        tick(1);
        chk("R3 ch0 500mA fault", int'(ocp_flag[0]), 1);
        set_cur(0, 0);
        pulse_clr();
        ch0_lowrds = 1'b1;
        set_cur(0, 1500);
        tick(20);
        chk("R3 ch0 1500 equal", int'(ocp_flag[0]), 0);
        set_cur(0, 1501);
        tick(16);
        chk("R3 ch0 1500mA fault", int'(ocp_flag[0]), 1);
        set_cur(0, 0);
        pulse_clr();

        // R4 protection off on channel 0
        ch0_ocp_off = 1'b1;
        set_cur(0, 4000);
        tick(80);
        chk("R4 ch0 disabled", int'(ocp_flag[0]), 0);
        chk("R4 ch0 drv on", int'(drv_en[0]), 1);
        set_cur(0, 0);
        ch0_ocp_off = 1'b0;

        // R7 counting only while commanded
        cmd_en[3] = 1'b0;
        set_cur(3, 1000);
        tick(20);
        chk("R7 idle no fault", int'(ocp_flag[3]), 0);
        chk("R7 drv low", int'(drv_en[3]), 0);
        cmd_en[3] = 1'b1;
        tick(7);
        cmd_en[3] = 1'b0;
        tick(1);
        cmd_en[3] = 1'b1;
        tick(7);
        chk("R7 gap restarts", int'(ocp_flag[3]), 0);
        tick(1);
        chk("R7 fault when active", int'(ocp_flag[3]), 1);
        set_cur(3, 0);
        pulse_clr();

        // R11 set beats clear on the same edge
        set_cur(5, 300);
        tick(8);
        chk("R11 ch5 latched", int'(ocp_flag[5]), 1);
        set_cur(5, 0);
        set_cur(4, 1000);
        tick(7);
        clr_flt = 1'b1;
        tick(1);
        clr_flt = 1'b0;
        chk("R11 ch4 set wins", int'(ocp_flag[4]), 1);
        chk("R11 ch5 cleared", int'(ocp_flag[5]), 0);
        set_cur(4, 0);
        pulse_clr();
        chk("R10 all clear", int'(ocp_flag), 0);

        tick(2);
        finish_run();
    end
endmodule